// File: doc/BRIEF.md
# Compare-Branch Fusion Detector

This block sits at the end of a decode stage and watches the two oldest decoded instructions of each cycle. When the older one is a flag-setting compare or test and the younger one is a conditional jump on a condition that the pairing rules accept, the two are merged into a single fused micro-op. That micro-op carries the compare operands together with the jump condition and target. It takes one slot downstream and is handled as one unit through execute and retire. Otherwise only the older instruction is issued, and the younger one is presented again in the next cycle.

The decision is the same in 32-bit and 64-bit operation. The mode bit only travels with the emitted micro-op. A separate saturating counter tallies fusion assists, which are the events where a fused op needed a machine clear. A pulse input drives it.

The emitted micro-op and the consumed count are registered, so each appears one clock after the slots that produced it.

Top module: `cmpbr_fuse`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs go to zero after that edge: `u_vld`, `u_fused`, `u_consumed`, the payload fields and `assist_cnt`.
- R2: Class encoding is 0 other, 1 compare, 2 test, 3 conditional jump. A test (class 2) in slot 0 and a conditional jump (class 3) in slot 1, both valid, fuse for every 4-bit condition code. The result is `u_fused`=1 and `u_consumed`=2.
- R3: A compare (class 1) followed by a valid conditional jump fuses when the jump's condition code is 2 to 7 or 12 to 15. These are the unsigned below/above families, equal/not-equal, and signed less, greater-or-equal, less-or-equal and greater.
- R4: A compare followed by a valid conditional jump whose condition code is 0, 1, 8, 9, 10 or 11 never fuses. These are the overflow, sign and parity conditions. The compare issues alone with `u_consumed`=1.
- R5: The pair does not fuse when slot 1 is invalid, when slot 1 is not a conditional jump, or when slot 0 is neither compare nor test. A valid slot 0 then issues alone with `u_consumed`=1, and the payload (class, condition code, operands, target) is slot 0's own.
- R6: A fused op carries slot 0's class and both operands, with slot 1's condition code and target.
- R7: `mode64` never changes the fusion decision. It is copied to `u_wide` of the issued op.
- R8: When slot 0 is invalid, `u_vld`=0, `u_fused`=0 and `u_consumed`=0, whatever slot 1 holds.
- R9: `assist_cnt` rises by one for each clock edge at which `assist_in` is high. It holds when `assist_in` is low and stops at all ones.
- R10: The issued op and the consumed count appear after the first clock edge following the input slots, and they do not change before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode64 | input | 1 | 1 selects 64-bit operation, 0 selects 32-bit operation |
| s0_vld | input | 1 | Slot 0 (older) valid |
| s0_cls | input | 2 | Slot 0 instruction class |
| s0_cc | input | 4 | Slot 0 condition code |
| s0_opa | input | 16 | Slot 0 first operand |
| s0_opb | input | 16 | Slot 0 second operand |
| s0_tgt | input | 32 | Slot 0 target |
| s1_vld | input | 1 | Slot 1 (younger) valid |
| s1_cls | input | 2 | Slot 1 instruction class |
| s1_cc | input | 4 | Slot 1 condition code |
| s1_tgt | input | 32 | Slot 1 branch target |
| assist_in | input | 1 | One fusion assist in this cycle |
| u_vld | output | 1 | Issued op valid |
| u_fused | output | 1 | Issued op is a fused pair |
| u_cls | output | 2 | Class of the issued op's head instruction |
| u_cc | output | 4 | Condition code of the issued op |
| u_opa | output | 16 | First operand |
| u_opb | output | 16 | Second operand |
| u_tgt | output | 32 | Target |
| u_wide | output | 1 | Mode bit carried with the op |
| u_consumed | output | 2 | Slots consumed: 0, 1 or 2 |
| assist_cnt | output | 8 | Saturating fusion-assist count |

## Verification
Each slot pattern is driven on a falling edge. The issued op and the consumed count are due after the next rising edge, so the bench samples them on the falling edge that follows. One directed case also samples just after driving and confirms the previous op is still shown. The assist counter changes on the same rising edge that sees the pulse, and it is read on the next falling edge. A reset is checked one edge after it is raised, in the same way.

// File: rtl/cbf_pkg.sv
package cbf_pkg;

    localparam int CC_W   = 4;
    localparam int OPND_W = 16;
    localparam int TGT_W  = 32;
    localparam int CNS_W  = 2;

    typedef enum logic [1:0] {
        CLS_OTHER = 2'd0,
        CLS_CMP   = 2'd1,
        CLS_TEST  = 2'd2,
        CLS_JCC   = 2'd3
    } icls_e;

    typedef struct packed {
        logic              vld;
        icls_e             cls;
        logic [CC_W-1:0]   cc;
        logic [OPND_W-1:0] opa;
        logic [OPND_W-1:0] opb;
        logic [TGT_W-1:0]  tgt;
    } slot_t;

    typedef struct packed {
        logic              vld;
        logic              fused;
        icls_e             cls;
        logic [CC_W-1:0]   cc;
        logic [OPND_W-1:0] opa;
        logic [OPND_W-1:0] opb;
        logic [TGT_W-1:0]  tgt;
        logic              wide;
    } uop_t;

    // Compare pairs only with flag conditions drawn from carry and zero,
    // or the signed relations; overflow, sign and parity tests are refused.
    function automatic logic cmp_cc_fusible(input logic [CC_W-1:0] cc);
        logic ok;
        case (cc)
            4'h0, 4'h1, 4'h8, 4'h9, 4'hA, 4'hB: ok = 1'b0;
            default:                            ok = 1'b1;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/cbf_pair_check.sv
module cbf_pair_check
    import cbf_pkg::*;
(
    input  logic            head_vld,
    input  icls_e           head_cls,
    input  logic            tail_vld,
    input  icls_e           tail_cls,
    input  logic [CC_W-1:0] tail_cc,
    output logic            fuse_ok
);
    logic head_flags;
    logic tail_branch;

    always_comb begin
        tail_branch = tail_vld && (tail_cls == CLS_JCC);
        case (head_cls)
            CLS_TEST: head_flags = 1'b1;
            CLS_CMP:  head_flags = cmp_cc_fusible(tail_cc);
            default:  head_flags = 1'b0;
        endcase
        fuse_ok = head_vld && tail_branch && head_flags;
    end
endmodule

// File: rtl/cbf_op_build.sv
module cbf_op_build
    import cbf_pkg::*;
(
    input  slot_t              head,
    input  logic [CC_W-1:0]    tail_cc,
    input  logic [TGT_W-1:0]   tail_tgt,
    input  logic               fuse_ok,
    input  logic               wide,
    output uop_t               uop,
    output logic [CNS_W-1:0]   consumed
);
    always_comb begin
        uop      = '0;
        consumed = '0;
        if (head.vld) begin
            uop.vld  = 1'b1;
            uop.cls  = head.cls;
            uop.opa  = head.opa;
            uop.opb  = head.opb;
            uop.wide = wide;
            if (fuse_ok) begin
                uop.fused = 1'b1;
                uop.cc    = tail_cc;
                uop.tgt   = tail_tgt;
                consumed  = CNS_W'(2);
            end else begin
                uop.cc    = head.cc;
                uop.tgt   = head.tgt;
                consumed  = CNS_W'(1);
            end
        end
    end
endmodule

// File: rtl/cbf_assist_ctr.sv
module cbf_assist_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pulse,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (pulse && (count != CNT_MAX))
            count <= count + 1'b1;
    end

    // R9
    assist_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse && count != CNT_MAX) |=> count == $past(count) + 1'b1);
    // R9
    assist_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse && count == CNT_MAX) |=> count == CNT_MAX);
    // R9
    assist_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pulse |=> $stable(count));
endmodule

// File: rtl/cmpbr_fuse.sv
module cmpbr_fuse
    import cbf_pkg::*;
#(
    parameter int ASSIST_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mode64,
    input  logic                s0_vld,
    input  logic [1:0]          s0_cls,
    input  logic [CC_W-1:0]     s0_cc,
    input  logic [OPND_W-1:0]   s0_opa,
    input  logic [OPND_W-1:0]   s0_opb,
    input  logic [TGT_W-1:0]    s0_tgt,
    input  logic                s1_vld,
    input  logic [1:0]          s1_cls,
    input  logic [CC_W-1:0]     s1_cc,
    input  logic [TGT_W-1:0]    s1_tgt,
    input  logic                assist_in,
    output logic                u_vld,
    output logic                u_fused,
    output logic [1:0]          u_cls,
    output logic [CC_W-1:0]     u_cc,
    output logic [OPND_W-1:0]   u_opa,
    output logic [OPND_W-1:0]   u_opb,
    output logic [TGT_W-1:0]    u_tgt,
    output logic                u_wide,
    output logic [CNS_W-1:0]    u_consumed,
    output logic [ASSIST_W-1:0] assist_cnt
);
    slot_t            head;
    logic             fuse_ok;
    uop_t             uop_nxt;
    uop_t             uop_q;
    logic [CNS_W-1:0] cns_nxt;
    logic [CNS_W-1:0] cns_q;

    always_comb begin
        head.vld = s0_vld;
        head.cls = icls_e'(s0_cls);
        head.cc  = s0_cc;
        head.opa = s0_opa;
        head.opb = s0_opb;
        head.tgt = s0_tgt;
    end

    cbf_pair_check pair_i (
        .head_vld (s0_vld),
        .head_cls (icls_e'(s0_cls)),
        .tail_vld (s1_vld),
        .tail_cls (icls_e'(s1_cls)),
        .tail_cc  (s1_cc),
        .fuse_ok  (fuse_ok)
    );

    cbf_op_build build_i (
        .head     (head),
        .tail_cc  (s1_cc),
        .tail_tgt (s1_tgt),
        .fuse_ok  (fuse_ok),
        .wide     (mode64),
        .uop      (uop_nxt),
        .consumed (cns_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            uop_q <= '0;
            cns_q <= '0;
        end else begin
            uop_q <= uop_nxt;
            cns_q <= cns_nxt;
        end
    end

    cbf_assist_ctr #(.CNT_W(ASSIST_W)) assist_i (
        .clk   (clk),
        .rst   (rst),
        .pulse (assist_in),
        .count (assist_cnt)
    );

    assign u_vld      = uop_q.vld;
    assign u_fused    = uop_q.fused;
    assign u_cls      = uop_q.cls;
    assign u_cc       = uop_q.cc;
    assign u_opa      = uop_q.opa;
    assign u_opb      = uop_q.opb;
    assign u_tgt      = uop_q.tgt;
    assign u_wide     = uop_q.wide;
    assign u_consumed = cns_q;

    // R2
    fused_two_chk: assert property (@(posedge clk) disable iff (rst)
        u_fused |-> (u_vld && u_consumed == CNS_W'(2)));
    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !u_vld |-> (u_consumed == '0 && !u_fused));
    // R4
    cmp_cc_chk: assert property (@(posedge clk) disable iff (rst)
        (u_fused && u_cls == CLS_CMP) |-> cmp_cc_fusible(u_cc));
    // R5
    no_branch_chk: assert property (@(posedge clk) disable iff (rst)
        (!s1_vld || s1_cls != CLS_JCC) |=> !u_fused);
    // R10
    issue_lat_chk: assert property (@(posedge clk) disable iff (rst)
        s0_vld |=> (u_vld && u_consumed != '0));
    // R7
    wide_copy_chk: assert property (@(posedge clk) disable iff (rst)
        s0_vld |=> u_wide == $past(mode64));
endmodule

// File: tb/cmpbr_fuse_tb_top.sv
module cmpbr_fuse_tb_top;
    localparam int CLK_P    = 10;
    localparam int ASSIST_W = 8;
    localparam int NVEC     = 17;

    // {v0, cls0[1:0], v1, cls1[1:0], cc1[3:0], mode, exp_fused, exp_consumed[1:0]}
    localparam logic [13:0] VEC [NVEC] = '{
        {1'b1, 2'd2, 1'b1, 2'd3, 4'h0, 1'b0, 1'b1, 2'd2}, // R2 test + overflow cc
        {1'b1, 2'd2, 1'b1, 2'd3, 4'h8, 1'b1, 1'b1, 2'd2}, // R2 test + sign cc
        {1'b1, 2'd2, 1'b1, 2'd3, 4'hA, 1'b0, 1'b1, 2'd2}, // R2 test + parity cc
        {1'b1, 2'd1, 1'b1, 2'd3, 4'h4, 1'b0, 1'b1, 2'd2}, // R3 equal
        {1'b1, 2'd1, 1'b1, 2'd3, 4'hC, 1'b1, 1'b1, 2'd2}, // R3 less
        {1'b1, 2'd1, 1'b1, 2'd3, 4'hF, 1'b0, 1'b1, 2'd2}, // R3 greater
        {1'b1, 2'd1, 1'b1, 2'd3, 4'h2, 1'b0, 1'b1, 2'd2}, // R3 below
        {1'b1, 2'd1, 1'b1, 2'd3, 4'h0, 1'b0, 1'b0, 2'd1}, // R4 overflow
        {1'b1, 2'd1, 1'b1, 2'd3, 4'h9, 1'b1, 1'b0, 2'd1}, // R4 not sign
        {1'b1, 2'd1, 1'b1, 2'd3, 4'hB, 1'b0, 1'b0, 2'd1}, // R4 not parity
        {1'b1, 2'd1, 1'b0, 2'd3, 4'h4, 1'b0, 1'b0, 2'd1}, // R5 tail invalid
        {1'b1, 2'd1, 1'b1, 2'd0, 4'h4, 1'b0, 1'b0, 2'd1}, // R5 tail not branch
        {1'b1, 2'd0, 1'b1, 2'd3, 4'h4, 1'b0, 1'b0, 2'd1}, // R5 head other
        {1'b1, 2'd3, 1'b1, 2'd3, 4'h4, 1'b1, 1'b0, 2'd1}, // R5 head branch
        {1'b0, 2'd2, 1'b1, 2'd3, 4'h4, 1'b0, 1'b0, 2'd0}, // R8 head invalid
        {1'b1, 2'd1, 1'b1, 2'd3, 4'hD, 1'b0, 1'b1, 2'd2}, // R7 32-bit
        {1'b1, 2'd1, 1'b1, 2'd3, 4'hD, 1'b1, 1'b1, 2'd2}  // R7 64-bit
    };

    logic        clk = 1'b0;
    logic        rst, mode64, s0_vld, s1_vld, assist_in;
    logic [1:0]  s0_cls, s1_cls;
    logic [3:0]  s0_cc, s1_cc;
    logic [15:0] s0_opa, s0_opb;
    logic [31:0] s0_tgt, s1_tgt;
    logic        u_vld, u_fused, u_wide;
    logic [1:0]  u_cls, u_consumed;
    logic [3:0]  u_cc;
    logic [15:0] u_opa, u_opb;
    logic [31:0] u_tgt;
    logic [ASSIST_W-1:0] assist_cnt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    cmpbr_fuse #(.ASSIST_W(ASSIST_W)) dut_i (
        .clk(clk), .rst(rst), .mode64(mode64),
        .s0_vld(s0_vld), .s0_cls(s0_cls), .s0_cc(s0_cc), .s0_opa(s0_opa),
        .s0_opb(s0_opb), .s0_tgt(s0_tgt),
        .s1_vld(s1_vld), .s1_cls(s1_cls), .s1_cc(s1_cc), .s1_tgt(s1_tgt),
        .assist_in(assist_in),
        .u_vld(u_vld), .u_fused(u_fused), .u_cls(u_cls), .u_cc(u_cc),
        .u_opa(u_opa), .u_opb(u_opb), .u_tgt(u_tgt), .u_wide(u_wide),
        .u_consumed(u_consumed), .assist_cnt(assist_cnt)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic drive(input logic v0, input logic [1:0] c0, input logic [3:0] cc0,
                         input logic v1, input logic [1:0] c1, input logic [3:0] cc1,
                         input logic m, input int seed);
        s0_vld = v0; s0_cls = c0; s0_cc = cc0;
        s0_opa = 16'h0100 + 16'(seed);
        s0_opb = 16'hA000 + 16'(seed * 3);
        s0_tgt = 32'h1000_0000 + 32'(seed);
        s1_vld = v1; s1_cls = c1; s1_cc = cc1;
        s1_tgt = 32'h2000_0000 + 32'(seed * 16);
        mode64 = m;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        rst = 1'b1; assist_in = 1'b0;
        drive(1'b1, 2'd2, 4'h3, 1'b1, 2'd3, 4'h4, 1'b1, 7);
        assist_in = 1'b1;
        @(posedge clk); @(negedge clk);
        // R1 reset state even with fusable slots present
        chk("R1 u_vld", u_vld, 0);
        chk("R1 u_fused", u_fused, 0);
        chk("R1 u_consumed", u_consumed, 0);
        chk("R1 u_tgt", u_tgt, 0);
        chk("R1 assist_cnt", assist_cnt, 0);
        rst = 1'b0; assist_in = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            logic [13:0] v;
            logic [3:0]  cc0;
            string       tag;
            v   = VEC[i];
            cc0 = 4'(i) ^ 4'h5;
            drive(v[13], v[12:11], cc0, v[10], v[9:8], v[7:4], v[3], i);
            @(posedge clk); @(negedge clk);
            if (v[2])                                      tag = (v[12:11] == 2'd2) ? "R2" : "R3";
            else if (!v[13])                               tag = "R8";
            else if (v[12:11] == 2'd1 && v[10] && v[9:8] == 2'd3) tag = "R4";
            else                                           tag = "R5";
            if (i >= NVEC - 2) tag = "R7";
            chk({tag, " fused"}, u_fused, v[2]);
            chk({tag, " consumed"}, u_consumed, v[1:0]);
            chk({tag, " valid"}, u_vld, (v[1:0] != 2'd0));
            if (v[1:0] != 2'd0) begin
                // R6 payload of fused op, R5 payload of single op
                chk("R6 cls", u_cls, v[12:11]);
                chk("R6 opa", u_opa, 16'h0100 + 16'(i));
                chk("R6 opb", u_opb, 16'hA000 + 16'(i * 3));
                chk("R6 cc", u_cc, v[2] ? v[7:4] : cc0);
                chk("R6 tgt", u_tgt, v[2] ? 32'h2000_0000 + 32'(i * 16)
                                          : 32'h1000_0000 + 32'(i));
                chk("R7 wide", u_wide, v[3]);
            end
        end

        // R10: unfused op shown, then fusable slots driven; old op held until edge
        drive(1'b1, 2'd1, 4'h6, 1'b1, 2'd3, 4'h8, 1'b0, 40);
        @(posedge clk); @(negedge clk);
        chk("R10 prior unfused", u_fused, 0);
        drive(1'b1, 2'd1, 4'h6, 1'b1, 2'd3, 4'hE, 1'b0, 41);
        #1;
        chk("R10 before edge", u_fused, 0);
        chk("R10 consumed before edge", u_consumed, 1);
        @(posedge clk); @(negedge clk);
        chk("R10 after edge", u_fused, 1);
        chk("R10 consumed after edge", u_consumed, 2);

        // R9 assist counting and hold
        drive(1'b0, 2'd0, 4'h0, 1'b0, 2'd0, 4'h0, 1'b0, 0);
        assist_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        assist_in = 1'b0;
        chk("R9 count three", assist_cnt, 3);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R9 hold", assist_cnt, 3);
        assist_in = 1'b1;
        repeat (300) @(posedge clk);
        @(negedge clk);
        chk("R9 saturate", assist_cnt, 8'hFF);
        assist_in = 1'b0;

        // R1 reset in mid-run clears op and counter
        drive(1'b1, 2'd2, 4'h1, 1'b1, 2'd3, 4'h2, 1'b1, 50);
        @(posedge clk); @(negedge clk);
        chk("R2 pre-reset fused", u_fused, 1);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1 mid reset fused", u_fused, 0);
        chk("R1 mid reset consumed", u_consumed, 0);
        chk("R1 mid reset assist", assist_cnt, 0);
        rst = 1'b0;

        done = 1'b1;
        summary();
    end
endmodule